// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers configuration-space reads and writes on behalf of a small, fixed group of bus/device/function slots. A host first loads a 32-bit configuration tag. The tag names a bus, a device, a function and a register offset. The host then issues data accesses of one to four bytes against that tag. Each present slot owns a 256-byte configuration store. Next to it sits a second 256-byte store that holds the size pattern returned during base-address sizing.

An access finds its slot from the latched tag. A read gathers bytes little-endian, starting at the tag offset and wrapping around the 256-byte space. A write lands only in the command/status word and the base-address registers. When software sizes a base-address register, it writes all ones to it. That write changes no stored value. It arms a one-shot flag, and the next read of the base-address window then returns the size pattern instead of the stored address. Functions that are not present give fixed read patterns, and writes to them are reported as errors.

Each access takes one cycle on the request side. The response is registered and appears on the following cycle.

Top module: `cfg_space_responder`

## Requirements
- R1: The tag loaded with `tag_we` is split into bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register offset = bits 7:0. An access goes to the slot whose {bus, device, function} equals the slot's entry in `SLOT_BDF`. Slot s uses bits 16s+15:16s of `SLOT_BDF`, packed as {bus[7:0], device[4:0], function[2:0]}. Bits 31:24 of the tag are ignored.
- R2: If tag bits 1:0 are not both zero, the response carries `rsp_misaligned` = 1. The access is still carried out as normal. For an aligned tag, `rsp_misaligned` is 0.
- R3: A read of an absent slot returns 0xFFFFFFFF when the register offset is 0x00, and returns 0x00000000 at any other offset.
- R4: A write to an absent slot changes nothing and responds with `rsp_err` = 1. All other accesses respond with `rsp_err` = 0.
- R5: For a read of `acc_len` bytes from a present slot, rdata byte lane i (bits 8i+7:8i) holds the byte at offset (offset + i) mod 256, for i < `acc_len`. Lanes at or above `acc_len` read as zero.
- R6: A probe write is a 4-byte write of 0xFFFFFFFF to a present slot at an offset from 0x10 to 0x24 inclusive. It stores nothing and arms the probe flag.
- R7: While the probe flag is armed, a read of a present slot at an offset from 0x10 to 0x24 takes its bytes from the size store. In that store, every base-address word at offsets 0x10 through 0x27 holds 0x000FFFFF.
- R8: Every read, including a read of an absent slot, disarms the probe flag. The next read of the same offset returns configuration-store contents again.
- R9: After reset, each slot returns `SLOT_ID` at offset 0x00, 0x00000003 at offset 0x04 (I/O enable in bit 0, memory enable in bit 1), `SLOT_CLASS` at offset 0x08, and zero at the base-address offsets. No probe is armed after reset.
- R10: Ordinary writes update only bytes at offsets 0x04 to 0x07 and 0x10 to 0x27, and only in the lanes below `acc_len`. Writes to any other offset, including the ID and class words, leave the store unchanged.
- R11: `rsp_valid` is high in exactly the cycle after each cycle in which `acc_valid` is high. Write responses return `rsp_rdata` = 0. During and right after reset, `rsp_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_we | input | 1 | Loads `tag_in` into the tag register |
| tag_in | input | 32 | Configuration tag (bus, device, function, offset) |
| acc_valid | input | 1 | Starts one data access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_len | input | 3 | Access length in bytes, 1 to 4 |
| acc_wdata | input | 32 | Write data, lane i goes to offset + i |
| rsp_valid | output | 1 | Response valid, one cycle after `acc_valid` |
| rsp_rdata | output | 32 | Read data, little-endian |
| rsp_misaligned | output | 1 | Tag offset had non-zero low bits |
| rsp_err | output | 1 | Write to an absent slot |

## Verification
The bench builds the block with three slots, a count that is not a power of two, so the slot index has a code that no slot uses. One slot sits at bus 2, device 31, function 7. At that slot every tag field is at or near its maximum, and neighbouring tags that differ in only one field must miss it. Each slot has its own identity and class words, so a read routed to the wrong slot shows up as a wrong value. The mix of probe writes, byte-length reads that wrap past offset 0xFF, and writes to read-only words exercises the probe flag and the write mask together.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int STORE_BYTES = 256;
  localparam int LANES       = 4;
  localparam int OFS_W       = $clog2(STORE_BYTES);

  localparam logic [OFS_W-1:0] CMD_FIRST = 8'h04;
  localparam logic [OFS_W-1:0] CMD_LAST  = 8'h07;
  localparam logic [OFS_W-1:0] BAR_FIRST = 8'h10;
  localparam logic [OFS_W-1:0] BAR_LAST  = 8'h24;  // last offset that starts a BAR access
  localparam logic [OFS_W-1:0] BAR_TAIL  = 8'h27;  // last byte of the final BAR word

  localparam logic [31:0] BAR_SIZE_WORD  = 32'h000F_FFFF;
  localparam logic [31:0] CMD_RESET_WORD = 32'h0000_0003;
  localparam logic [31:0] PROBE_PATTERN  = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [7:0]       bus;
    logic [4:0]       dev;
    logic [2:0]       func;
    logic [OFS_W-1:0] ofs;
  } cfg_tag_t;

  function automatic cfg_tag_t split_tag(input logic [31:0] t);
    cfg_tag_t r;
    r.bus  = t[23:16];
    r.dev  = t[15:11];
    r.func = t[10:8];
    r.ofs  = t[7:0];
    return r;
  endfunction

  function automatic logic [15:0] bdf_key(input cfg_tag_t t);
    return {t.bus, t.dev, t.func};
  endfunction

  function automatic logic in_bar_window(input logic [OFS_W-1:0] o);
    return (o >= BAR_FIRST) && (o <= BAR_LAST);
  endfunction

  function automatic logic byte_writable(input logic [OFS_W-1:0] o);
    return ((o >= CMD_FIRST) && (o <= CMD_LAST)) ||
           ((o >= BAR_FIRST) && (o <= BAR_TAIL));
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] len);
    case (len)
      3'd0, 3'd1: return 4'b0001;
      3'd2:       return 4'b0011;
      3'd3:       return 4'b0111;
      default:    return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lanes_to_bits(input logic [LANES-1:0] m);
    logic [31:0] r;
    for (int l = 0; l < LANES; l++) r[8*l +: 8] = {8{m[l]}};
    return r;
  endfunction

  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] size_byte(input logic [OFS_W-1:0] o);
    if ((o >= BAR_FIRST) && (o <= BAR_TAIL)) return word_byte(BAR_SIZE_WORD, o[1:0]);
    return 8'h00;
  endfunction

  function automatic logic [7:0] init_byte(input logic [OFS_W-1:0] o,
                                           input logic [31:0] id_word,
                                           input logic [31:0] class_word);
    case (o[OFS_W-1:2])
      6'd0:    return word_byte(id_word, o[1:0]);
      6'd1:    return word_byte(CMD_RESET_WORD, o[1:0]);
      6'd2:    return word_byte(class_word, o[1:0]);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_tag_decode.sv
module cfg_tag_decode
  import cfgsp_pkg::*;
#(
  parameter int                    NUM_SLOTS = 2,
  parameter logic [NUM_SLOTS*16-1:0] SLOT_BDF = '0,
  localparam int                   IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic [31:0]      tag_in,
  output cfg_tag_t         tag_q,
  output logic             slot_hit,
  output logic [IDX_W-1:0] slot_idx,
  output logic             tag_misaligned
);

  logic [NUM_SLOTS-1:0] slot_match;
  logic [7:0]           unused_tag_hi;

  assign unused_tag_hi = tag_in[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_we) tag_q <= split_tag(tag_in);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
    assign slot_match[s] = (bdf_key(tag_q) == SLOT_BDF[16*s +: 16]);
  end

  always_comb begin
    slot_idx = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_match[s]) slot_idx = IDX_W'(s);
    end
  end

  assign slot_hit       = |slot_match;
  assign tag_misaligned = |tag_q.ofs[1:0];

endmodule

// File: rtl/cfg_slot_store.sv
module cfg_slot_store
  import cfgsp_pkg::*;
#(
  parameter logic [31:0] SLOT_ID    = 32'h0000_0000,
  parameter logic [31:0] SLOT_CLASS = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [31:0]      wr_data,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [31:0]      cfg_rd,
  output logic [31:0]      size_rd
);

  logic [7:0] cfg_mem  [STORE_BYTES];
  logic [7:0] size_mem [STORE_BYTES];

  // Configuration store: loaded from parameters, written in the allowed ranges.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_BYTES; i++)
        cfg_mem[i] <= init_byte(OFS_W'(i), SLOT_ID, SLOT_CLASS);
    end else if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l] && byte_writable(wr_ofs + OFS_W'(l)))
          cfg_mem[wr_ofs + OFS_W'(l)] <= wr_data[8*l +: 8];
      end
    end
  end

  // Size store: only reset loads it; sizing answers come from here.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_BYTES; i++)
        size_mem[i] <= size_byte(OFS_W'(i));
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      cfg_rd[8*l +: 8]  = cfg_mem[rd_ofs + OFS_W'(l)];
      size_rd[8*l +: 8] = size_mem[rd_ofs + OFS_W'(l)];
    end
  end

endmodule

// File: rtl/cfg_probe_ctl.sv
module cfg_probe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic armed
);

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (disarm) armed <= 1'b0;
    else if (arm)    armed <= 1'b1;
  end

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
  import cfgsp_pkg::*;
#(
  parameter int                      NUM_SLOTS  = 2,
  parameter logic [NUM_SLOTS*16-1:0] SLOT_BDF   = {16'h0008, 16'h0000},
  parameter logic [NUM_SLOTS*32-1:0] SLOT_ID    = {32'h0002_1AF4, 32'h0001_1AF4},
  parameter logic [NUM_SLOTS*32-1:0] SLOT_CLASS = {32'h0200_0001, 32'h0600_0001}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tag_we,
  input  logic [31:0] tag_in,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [2:0]  acc_len,
  input  logic [31:0] acc_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_misaligned,
  output logic        rsp_err
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  cfg_tag_t         tag_q;
  logic             slot_hit;
  logic [IDX_W-1:0] slot_idx;
  logic             tag_misaligned;

  cfg_tag_decode #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BDF  (SLOT_BDF)
  ) u_decode (
    .clk            (clk),
    .rst_n          (rst_n),
    .tag_we         (tag_we),
    .tag_in         (tag_in),
    .tag_q          (tag_q),
    .slot_hit       (slot_hit),
    .slot_idx       (slot_idx),
    .tag_misaligned (tag_misaligned)
  );

  // Access classification, brought out as named events.
  logic             is_read;
  logic             is_write;
  logic             probe_fire;
  logic             store_wr;
  logic             absent_wr;
  logic             probe_armed;
  logic [LANES-1:0] len_lanes;

  assign len_lanes  = lane_mask(acc_len);
  assign is_read    = acc_valid && !acc_write;
  assign is_write   = acc_valid && acc_write;
  assign probe_fire = is_write && slot_hit && (acc_len == 3'd4) &&
                      (acc_wdata == PROBE_PATTERN) && in_bar_window(tag_q.ofs);
  assign store_wr   = is_write && slot_hit && !probe_fire;
  assign absent_wr  = is_write && !slot_hit;

  cfg_probe_ctl u_probe (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (probe_fire),
    .disarm (is_read),
    .armed  (probe_armed)
  );

  logic [31:0] cfg_rd_all  [NUM_SLOTS];
  logic [31:0] size_rd_all [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    cfg_slot_store #(
      .SLOT_ID    (SLOT_ID[32*s +: 32]),
      .SLOT_CLASS (SLOT_CLASS[32*s +: 32])
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (store_wr && (slot_idx == IDX_W'(s))),
      .wr_ofs   (tag_q.ofs),
      .wr_data  (acc_wdata),
      .wr_lanes (len_lanes),
      .rd_ofs   (tag_q.ofs),
      .cfg_rd   (cfg_rd_all[s]),
      .size_rd  (size_rd_all[s])
    );
  end

  // Read word selection.
  logic [31:0] rd_word;
  logic        use_size;

  assign use_size = probe_armed && in_bar_window(tag_q.ofs);

  always_comb begin
    if (!slot_hit)
      rd_word = (tag_q.ofs == '0) ? 32'hFFFF_FFFF : 32'h0000_0000;
    else if (use_size)
      rd_word = size_rd_all[slot_idx] & lanes_to_bits(len_lanes);
    else
      rd_word = cfg_rd_all[slot_idx] & lanes_to_bits(len_lanes);
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_misaligned <= 1'b0;
      rsp_err        <= 1'b0;
    end else begin
      rsp_valid      <= acc_valid;
      rsp_rdata      <= is_read ? rd_word : '0;
      rsp_misaligned <= acc_valid && tag_misaligned;
      rsp_err        <= absent_wr;
    end
  end

endmodule

// File: rtl/cfg_space_responder_chk.sv
module cfg_space_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [2:0]  acc_len,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_misaligned,
  input logic        rsp_err,
  input logic        slot_hit,
  input logic        tag_misaligned,
  input logic        probe_fire,
  input logic        probe_armed
);

  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  a_r11_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> rsp_rdata == 32'h0);

  a_r4_err_only_absent_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(acc_valid) && $past(acc_write) && !$past(slot_hit));

  a_r3_absent_read_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && !slot_hit |=> (rsp_rdata == 32'hFFFF_FFFF) || (rsp_rdata == 32'h0));

  a_r2_misaligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_misaligned == $past(tag_misaligned));

  a_r5_single_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && slot_hit && acc_len == 3'd1 |=> rsp_rdata[31:8] == 24'h0);

  a_r6_probe_arms: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fire |=> probe_armed);

  a_r8_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |=> !probe_armed);

endmodule

bind cfg_space_responder cfg_space_responder_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .acc_len        (acc_len),
  .rsp_valid      (rsp_valid),
  .rsp_rdata      (rsp_rdata),
  .rsp_misaligned (rsp_misaligned),
  .rsp_err        (rsp_err),
  .slot_hit       (slot_hit),
  .tag_misaligned (tag_misaligned),
  .probe_fire     (probe_fire),
  .probe_armed    (probe_armed)
);

// File: tb/cfg_space_responder_tb.sv
`timescale 1ns/1ps
module cfg_space_responder_tb;

  localparam int NS = 3;
  localparam logic [NS*16-1:0] BDF = {16'h02FF, 16'h0029, 16'h0000};
  localparam logic [NS*32-1:0] IDS = {32'hDEADBEEF, 32'h55AA0F0F, 32'h1234ABCD};
  localparam logic [NS*32-1:0] CLS = {32'h01018003, 32'h02000010, 32'h06000001};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tag_we = 1'b0;
  logic [31:0] tag_in = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_len = 3'd4;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_misaligned;
  logic        rsp_err;

  always #4 clk = ~clk;  // 125 MHz

  cfg_space_responder #(
    .NUM_SLOTS  (NS),
    .SLOT_BDF   (BDF),
    .SLOT_ID    (IDS),
    .SLOT_CLASS (CLS)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tag_we         (tag_we),
    .tag_in         (tag_in),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_len        (acc_len),
    .acc_wdata      (acc_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .rsp_misaligned (rsp_misaligned),
    .rsp_err        (rsp_err)
  );

  logic [7:0] mdl [NS][256];
  bit         mdl_probe;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // R1: tag fields bus 23:16, device 15:11, function 10:8.
  function automatic int b_find(input logic [31:0] t);
    for (int s = 0; s < NS; s++) begin
      if (t[23:16] == BDF[16*s+8 +: 8] && t[15:11] == BDF[16*s+3 +: 5] && t[10:8] == BDF[16*s +: 3])
        return s;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mk_tag(input int s, input int r);
    return {8'h00, BDF[16*s +: 16], 8'(r)};
  endfunction

  // R7: size word 0x000FFFFF across 0x10..0x27.
  function automatic logic [7:0] b_size(input int o);
    if (o < 16 || o > 39) return 8'h00;
    case (o % 4)
      0, 1:    return 8'hFF;
      2:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  // R10: writable bytes.
  function automatic bit b_wr(input int o);
    return (o >= 4 && o <= 7) || (o >= 16 && o <= 39);
  endfunction

  task automatic mdl_reset();
    for (int s = 0; s < NS; s++) begin
      for (int o = 0; o < 256; o++) mdl[s][o] = 8'h00;
      for (int b = 0; b < 4; b++) begin
        mdl[s][b]     = IDS[32*s + 8*b +: 8];   // R9 identity
        mdl[s][8 + b] = CLS[32*s + 8*b +: 8];   // R9 class
      end
      mdl[s][4] = 8'h03;                       // R9 I/O + memory enable
    end
    mdl_probe = 1'b0;
  endtask

  task automatic access(input logic [31:0] tag, input bit wr, input int len,
                        input logic [31:0] data, input string req);
    int          s;
    int          r;
    logic [31:0] exp_d;
    bit          exp_e;
    bit          exp_m;
    s     = b_find(tag);
    r     = int'(tag[7:0]);
    exp_d = '0;
    exp_e = 1'b0;
    exp_m = (tag[1:0] != 2'b00);
    if (!wr) begin
      if (s < 0) exp_d = (r == 0) ? 32'hFFFF_FFFF : 32'h0;
      else begin
        for (int i = 0; i < len; i++) begin
          int o = (r + i) % 256;
          exp_d[8*i +: 8] = (mdl_probe && r >= 16 && r <= 36) ? b_size(o) : mdl[s][o];
        end
      end
      mdl_probe = 1'b0;
    end else begin
      if (s < 0) exp_e = 1'b1;
      else if (len == 4 && data == 32'hFFFF_FFFF && r >= 16 && r <= 36) mdl_probe = 1'b1;
      else begin
        for (int i = 0; i < len; i++) begin
          int o = (r + i) % 256;
          if (b_wr(o)) mdl[s][o] = data[8*i +: 8];
        end
      end
    end
    @(negedge clk);
    tag_we = 1'b1;
    tag_in = tag;
    @(negedge clk);
    tag_we    = 1'b0;
    acc_valid = 1'b1;
    acc_write = wr;
    acc_len   = 3'(len);
    acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(rsp_valid == 1'b1, {"R11 ", req}, {31'h0, rsp_valid}, 32'h1);
    chk(rsp_rdata == exp_d, req, rsp_rdata, exp_d);
    chk(rsp_err == exp_e, {"R4 ", req}, {31'h0, rsp_err}, {31'h0, exp_e});
    chk(rsp_misaligned == exp_m, {"R2 ", req}, {31'h0, rsp_misaligned}, {31'h0, exp_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mdl_reset();
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R11 reset outputs", {30'h0, rsp_valid, rsp_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 idle after reset", {31'h0, rsp_valid}, 32'h0);

    // R9 reset contents
    access(mk_tag(0, 8'h00), 1'b0, 4, 0, "R9 id");
    chk(rsp_rdata == 32'h1234ABCD, "R9 id literal", rsp_rdata, 32'h1234ABCD);
    access(mk_tag(0, 8'h04), 1'b0, 4, 0, "R9 cmd");
    chk(rsp_rdata == 32'h00000003, "R9 cmd literal", rsp_rdata, 32'h3);
    access(mk_tag(1, 8'h08), 1'b0, 4, 0, "R9 class");
    access(mk_tag(1, 8'h10), 1'b0, 4, 0, "R9 bar zero");

    // R1 slot routing, R3 absent slot
    access(mk_tag(2, 8'h00), 1'b0, 4, 0, "R1 slot2 id");
    chk(rsp_rdata == 32'hDEADBEEF, "R1 slot2 literal", rsp_rdata, 32'hDEADBEEF);
    access(32'h0000_2A00, 1'b0, 4, 0, "R3 absent reg0");
    chk(rsp_rdata == 32'hFFFFFFFF, "R3 absent literal", rsp_rdata, 32'hFFFFFFFF);
    access(32'h0001_0008, 1'b0, 4, 0, "R3 absent reg8");
    access(32'hFF00_2900, 1'b0, 4, 0, "R1 upper tag bits ignored");

    // R4 absent write
    access(32'h0003_0004, 1'b1, 4, 32'h0, "R4 absent write");
    chk(rsp_err == 1'b1, "R4 err literal", {31'h0, rsp_err}, 32'h1);

    // R10 write masking
    access(mk_tag(0, 8'h00), 1'b1, 4, 32'h0, "R10 id write");
    access(mk_tag(0, 8'h00), 1'b0, 4, 0, "R10 id unchanged");
    chk(rsp_rdata == 32'h1234ABCD, "R10 id literal", rsp_rdata, 32'h1234ABCD);
    access(mk_tag(0, 8'h10), 1'b1, 4, 32'h12345670, "R10 bar write");
    access(mk_tag(0, 8'h10), 1'b0, 4, 0, "R10 bar readback");
    access(mk_tag(0, 8'h06), 1'b1, 2, 32'hAAAA_0290, "R10 status half");
    access(mk_tag(0, 8'h04), 1'b0, 4, 0, "R10 cmd word");

    // R6/R7/R8 sizing probe
    access(mk_tag(0, 8'h14), 1'b1, 4, 32'hFFFFFFFF, "R6 probe write");
    access(mk_tag(0, 8'h14), 1'b0, 4, 0, "R7 size read");
    chk(rsp_rdata == 32'h000FFFFF, "R7 size literal", rsp_rdata, 32'h000FFFFF);
    access(mk_tag(0, 8'h14), 1'b0, 4, 0, "R8 second read");
    chk(rsp_rdata == 32'h0, "R8 config again", rsp_rdata, 32'h0);
    access(mk_tag(0, 8'h10), 1'b1, 4, 32'hFFFFFFFF, "R6 probe over value");
    access(mk_tag(0, 8'h10), 1'b0, 4, 0, "R7 size over value");
    access(mk_tag(0, 8'h10), 1'b0, 4, 0, "R6 value kept");
    chk(rsp_rdata == 32'h12345670, "R6 value literal", rsp_rdata, 32'h12345670);
    access(mk_tag(2, 8'h24), 1'b1, 4, 32'hFFFFFFFF, "R6 probe last bar");
    access(32'h0004_0000, 1'b0, 4, 0, "R8 absent read disarms");
    access(mk_tag(2, 8'h24), 1'b0, 4, 0, "R8 after absent read");
    access(mk_tag(1, 8'h28), 1'b1, 4, 32'hFFFFFFFF, "R6 outside window");
    access(mk_tag(1, 8'h28), 1'b0, 4, 0, "R10 outside window");

    // R5 little-endian, wrap, lane masking; R2 misaligned
    access(mk_tag(0, 8'hFF), 1'b0, 2, 0, "R5 wrap");
    chk(rsp_rdata == 32'h0000CD00, "R5 wrap literal", rsp_rdata, 32'h0000CD00);
    access(mk_tag(0, 8'h12), 1'b0, 1, 0, "R5 single byte");
    access(mk_tag(0, 8'h11), 1'b0, 3, 0, "R2 misaligned read");
    chk(rsp_misaligned == 1'b1, "R2 flag literal", {31'h0, rsp_misaligned}, 32'h1);
    access(mk_tag(1, 8'h13), 1'b1, 4, 32'hCAFEF00D, "R2 misaligned write");
    access(mk_tag(1, 8'h10), 1'b0, 4, 0, "R2 write landed");
    access(mk_tag(1, 8'h14), 1'b0, 4, 0, "R2 write landed hi");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] tg;
      int          pick;
      int          r;
      int          len;
      bit          wr;
      logic [31:0] d;
      pick = int'($urandom % 8);
      case (int'($urandom % 6))
        0:       r = 0;
        1:       r = 4 + int'($urandom % 4);
        2:       r = 252 + int'($urandom % 4);
        3:       r = int'($urandom % 256);
        default: r = 16 + int'($urandom % 24);
      endcase
      if (pick < 6) tg = mk_tag(pick % NS, r);
      else          tg = {8'h00, 16'($urandom), 8'(r)};
      len = 1 + int'($urandom % 4);
      wr  = ($urandom % 2) == 1;
      d   = $urandom;
      if (wr && ($urandom % 3) == 0) begin
        len = 4;
        d   = 32'hFFFFFFFF;
      end
      access(tg, wr, len, d, "RND R5 R7 R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule